// File: doc/BRIEF.md
# Multi-Core Launch Controller

This block is the central arbiter that starts cores in a cluster of identical processing cores. Any core may post a launch request made of a packed descriptor word, a target core number and three flags: allocate (pick any idle core instead of the named one), execute-in-place (run straight from shared memory instead of loading a program first), and register-sourced (the requester can take back the chosen core number). Requests from several cores are served one per cycle in round-robin order, so each launch is a single atomic operation with its target named inside the request.

The descriptor carries two long-aligned pointers in one word. The low half is the start long address, which is also copied into the target core's second pointer register. The high half goes to its first pointer register. A load-mode launch raises a per-core copy request towards an external copy engine, whose source is the second pointer, and starts the core once the engine reports done. An execute-in-place launch starts the core at once. When its address lies below the core-local memory size, it jumps into local memory without loading anything. Restarting a core that is already active stops it and applies the new launch on the same clock edge.

Top module: `launch_ctrl`

## Requirements
- R1: After reset every core is idle (`core_busy` low), all pointers are zero, and `core_go`, `core_stop`, `copy_req`, `rsp_valid` and `req_gnt` are low.
- R2: On a granted launch, the target core's `core_ptrb` takes descriptor bits [15:0] and `core_ptra` takes bits [31:16], visible in the cycle after the grant.
- R3: A request with `req_alloc` low launches exactly the core given in `req_core`, and `rsp_core` returns that number.
- R4: Launching a core that is not idle pulses its `core_stop` for one cycle in the cycle after the grant, with the new pointers and start already applied and `core_busy` staying high.
- R5: A request with `req_alloc` high launches the lowest-numbered idle core and returns its number in `rsp_core`.
- R6: An allocate request finding no idle core sets `rsp_nofree` and changes no core: no `core_go`, no `core_stop`, no pointer change.
- R7: `rsp_wr` is high only for a granted allocate request whose `req_reg` is high; an allocate with `req_reg` low gives no write-back.
- R8: A load-mode launch (`req_hubx` low) holds `copy_req` of the target from the cycle after the grant until `copy_done`; one cycle after `copy_done` the core gets `core_go` with `core_hub` low and `core_pc` zero, and `copy_req` drops.
- R9: An execute-in-place launch with start address at or above 0x200 gives `core_go` in the cycle after the grant with `core_hub` high, `core_pc` equal to descriptor bits [15:0], and no copy request.
- R10: An execute-in-place launch with start address below 0x200 gives `core_go` with `core_hub` low and `core_pc` equal to the address, with no copy request.
- R11: `req_gnt` is one-hot or zero; simultaneous requests are granted one per cycle, starting from the requester after the last one granted (requester 0 first after reset); `rsp_id` names the requester served.
- R12: `core_halt` on a running core that is not being launched makes it idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_CORES | Launch request per requester, held until granted |
| req_desc | input | NUM_CORES*2*PTR_W | Packed descriptor per requester |
| req_core | input | NUM_CORES*CID_W | Named target core per requester |
| req_alloc | input | NUM_CORES | 1 = pick the lowest idle core |
| req_hubx | input | NUM_CORES | 1 = execute in place, 0 = load first |
| req_reg | input | NUM_CORES | 1 = descriptor came from a register, result is written back |
| req_gnt | output | NUM_CORES | Grant, combinational, one-hot or zero |
| rsp_valid | output | 1 | Response valid, cycle after grant |
| rsp_id | output | CID_W | Requester served |
| rsp_core | output | CID_W | Core launched |
| rsp_nofree | output | 1 | Allocate found no idle core |
| rsp_wr | output | 1 | Result is to be written back |
| core_halt | input | NUM_CORES | Core reports it has stopped |
| core_stop | output | NUM_CORES | Forced stop pulse on restart |
| core_go | output | NUM_CORES | Start pulse |
| core_hub | output | NUM_CORES | Start executes from shared memory |
| core_pc | output | NUM_CORES*PTR_W | Start long address |
| core_ptra | output | NUM_CORES*PTR_W | First pointer register per core |
| core_ptrb | output | NUM_CORES*PTR_W | Second pointer register per core, copy source |
| core_busy | output | NUM_CORES | Core is loading or running |
| copy_req | output | NUM_CORES | Copy wanted for this core |
| copy_done | input | NUM_CORES | Copy engine finished for this core |

## Verification
The bench builds the block with four cores, 16-bit pointers and a 512-long local memory, the default values. Four cores are few enough to fill every slot, which brings the no-free-core path and the lowest-idle search around a hole within reach. Four requesters let a three-way collision show the round-robin rotation wrapping past the top index. The 512 limit puts the execute-in-place boundary at 0x1FF and 0x200, both of which are driven.

// File: rtl/launch_pkg.sv
package launch_pkg;

   typedef enum logic [1:0] {
      SLOT_IDLE = 2'd0,
      SLOT_LOAD = 2'd1,
      SLOT_RUN  = 2'd2
   } slot_state_e;

endpackage

// File: rtl/launch_rr_arb.sv
module launch_rr_arb #(
   parameter int N = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         req,
   output logic [N-1:0]         gnt,
   output logic [$clog2(N)-1:0] gnt_idx
);
   localparam int IW = $clog2(N);

   logic [IW-1:0] last_q;
   logic          found;
   logic [IW-1:0] idx;

   always_comb begin
      gnt     = '0;
      gnt_idx = '0;
      found   = 1'b0;
      idx     = '0;
      for (int k = 1; k <= N; k++) begin
         idx = IW'((int'(last_q) + k) % N);
         if (!found && req[idx]) begin
            found        = 1'b1;
            gnt[idx]     = 1'b1;
            gnt_idx      = idx;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= IW'(N - 1);
      else if (found) last_q <= gnt_idx;
   end

   p_gnt_onehot_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   p_gnt_needs_req_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
   p_rotate_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (found && req == {N{1'b1}}) |=> (!found || gnt_idx != $past(gnt_idx)));

endmodule

// File: rtl/launch_slot.sv
module launch_slot
   import launch_pkg::*;
#(
   parameter int PTR_W       = 16,
   parameter int LOCAL_LONGS = 512
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch,
   input  logic               hubx,
   input  logic [2*PTR_W-1:0] desc,
   input  logic               halt,
   input  logic               copy_done,
   output logic               busy,
   output logic               stop,
   output logic               go,
   output logic               hub,
   output logic [PTR_W-1:0]   pc,
   output logic [PTR_W-1:0]   ptra,
   output logic [PTR_W-1:0]   ptrb,
   output logic               copy_req
);
   localparam logic [PTR_W-1:0] LOCAL_LIM = PTR_W'(LOCAL_LONGS);

   slot_state_e      state_q;
   logic             stop_q, go_q, hub_q;
   logic [PTR_W-1:0] pc_q, ptra_q, ptrb_q;
   logic [PTR_W-1:0] start_addr;

   assign start_addr = desc[PTR_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SLOT_IDLE;
         stop_q  <= 1'b0;
         go_q    <= 1'b0;
         hub_q   <= 1'b0;
         pc_q    <= '0;
         ptra_q  <= '0;
         ptrb_q  <= '0;
      end else begin
         stop_q <= 1'b0;
         go_q   <= 1'b0;
         if (launch) begin
            stop_q <= (state_q != SLOT_IDLE);
            ptra_q <= desc[2*PTR_W-1:PTR_W];
            ptrb_q <= start_addr;
            if (hubx) begin
               state_q <= SLOT_RUN;
               go_q    <= 1'b1;
               hub_q   <= (start_addr >= LOCAL_LIM);
               pc_q    <= start_addr;
            end else begin
               state_q <= SLOT_LOAD;
            end
         end else if (state_q == SLOT_LOAD && copy_done) begin
            state_q <= SLOT_RUN;
            go_q    <= 1'b1;
            hub_q   <= 1'b0;
            pc_q    <= '0;
         end else if (state_q == SLOT_RUN && halt) begin
            state_q <= SLOT_IDLE;
         end
      end
   end

   assign busy     = (state_q != SLOT_IDLE);
   assign stop     = stop_q;
   assign go       = go_q;
   assign hub      = hub_q;
   assign pc       = pc_q;
   assign ptra     = ptra_q;
   assign ptrb     = ptrb_q;
   assign copy_req = (state_q == SLOT_LOAD);

   p_ptr_load_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (ptrb == $past(start_addr) && ptra == $past(desc[2*PTR_W-1:PTR_W])));
   p_restart_busy_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (launch && busy) |=> (stop && busy));
   p_copy_end_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (copy_req && copy_done && !launch) |=> (go && !hub && !copy_req));
   p_xip_nocopy_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (launch && hubx) |=> (go && !copy_req));
   p_halt_idle_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SLOT_RUN && halt && !launch) |=> !busy);

endmodule

// File: rtl/launch_ctrl.sv
module launch_ctrl #(
   parameter int NUM_CORES   = 4,
   parameter int PTR_W       = 16,
   parameter int LOCAL_LONGS = 512,
   localparam int CID_W      = $clog2(NUM_CORES),
   localparam int DESC_W     = 2 * PTR_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_CORES-1:0]        req_valid,
   input  logic [NUM_CORES*DESC_W-1:0] req_desc,
   input  logic [NUM_CORES*CID_W-1:0]  req_core,
   input  logic [NUM_CORES-1:0]        req_alloc,
   input  logic [NUM_CORES-1:0]        req_hubx,
   input  logic [NUM_CORES-1:0]        req_reg,
   output logic [NUM_CORES-1:0]        req_gnt,
   output logic                        rsp_valid,
   output logic [CID_W-1:0]            rsp_id,
   output logic [CID_W-1:0]            rsp_core,
   output logic                        rsp_nofree,
   output logic                        rsp_wr,
   input  logic [NUM_CORES-1:0]        core_halt,
   output logic [NUM_CORES-1:0]        core_stop,
   output logic [NUM_CORES-1:0]        core_go,
   output logic [NUM_CORES-1:0]        core_hub,
   output logic [NUM_CORES*PTR_W-1:0]  core_pc,
   output logic [NUM_CORES*PTR_W-1:0]  core_ptra,
   output logic [NUM_CORES*PTR_W-1:0]  core_ptrb,
   output logic [NUM_CORES-1:0]        core_busy,
   output logic [NUM_CORES-1:0]        copy_req,
   input  logic [NUM_CORES-1:0]        copy_done
);

   if (NUM_CORES < 2 || NUM_CORES != (1 << CID_W)) begin : g_bad_cores
      $error("launch_ctrl: NUM_CORES must be a power of two, at least 2");
   end
   if (PTR_W < 2 || LOCAL_LONGS < 1 || LOCAL_LONGS >= (1 << PTR_W)) begin : g_bad_ptr
      $error("launch_ctrl: LOCAL_LONGS must fit below 2**PTR_W");
   end

   logic [CID_W-1:0]     gnt_idx;
   logic                 any_gnt;
   logic [DESC_W-1:0]    sel_desc;
   logic [CID_W-1:0]     sel_core;
   logic                 sel_alloc, sel_hubx, sel_reg;
   logic                 free_found;
   logic [CID_W-1:0]     free_idx;
   logic [CID_W-1:0]     target;
   logic                 do_launch;
   logic [NUM_CORES-1:0] launch_vec;

   launch_rr_arb #(.N(NUM_CORES)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_valid),
      .gnt     (req_gnt),
      .gnt_idx (gnt_idx)
   );

   assign any_gnt   = |req_gnt;
   assign sel_desc  = req_desc[gnt_idx*DESC_W +: DESC_W];
   assign sel_core  = req_core[gnt_idx*CID_W +: CID_W];
   assign sel_alloc = req_alloc[gnt_idx];
   assign sel_hubx  = req_hubx[gnt_idx];
   assign sel_reg   = req_reg[gnt_idx];

   always_comb begin
      free_found = 1'b0;
      free_idx   = '0;
      for (int i = NUM_CORES - 1; i >= 0; i--) begin
         if (!core_busy[i]) begin
            free_found = 1'b1;
            free_idx   = CID_W'(i);
         end
      end
   end

   assign target     = sel_alloc ? free_idx : sel_core;
   assign do_launch  = any_gnt && (!sel_alloc || free_found);
   assign launch_vec = do_launch ? (NUM_CORES'(1) << target) : '0;

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
      launch_slot #(.PTR_W(PTR_W), .LOCAL_LONGS(LOCAL_LONGS)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .launch    (launch_vec[c]),
         .hubx      (sel_hubx),
         .desc      (sel_desc),
         .halt      (core_halt[c]),
         .copy_done (copy_done[c]),
         .busy      (core_busy[c]),
         .stop      (core_stop[c]),
         .go        (core_go[c]),
         .hub       (core_hub[c]),
         .pc        (core_pc[c*PTR_W +: PTR_W]),
         .ptra      (core_ptra[c*PTR_W +: PTR_W]),
         .ptrb      (core_ptrb[c*PTR_W +: PTR_W]),
         .copy_req  (copy_req[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_id     <= '0;
         rsp_core   <= '0;
         rsp_nofree <= 1'b0;
         rsp_wr     <= 1'b0;
      end else begin
         rsp_valid  <= any_gnt;
         rsp_id     <= gnt_idx;
         rsp_core   <= do_launch ? target : '0;
         rsp_nofree <= any_gnt && sel_alloc && !free_found;
         rsp_wr     <= any_gnt && sel_alloc && sel_reg;
      end
   end

   p_nofree_full_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_nofree) |-> ($past(&core_busy) && core_stop == '0));
   p_wr_needs_rsp_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_wr |-> rsp_valid);
   p_one_launch_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      $countones(core_stop) <= 1);

endmodule

// File: tb/tb_launch_ctrl.sv
module tb_launch_ctrl;
   localparam int N  = 4;
   localparam int PW = 16;
   localparam int CW = 2;
   localparam int DW = 32;

   logic            clk, rst_n;
   logic [N-1:0]    req_valid, req_alloc, req_hubx, req_reg, req_gnt;
   logic [N*DW-1:0] req_desc;
   logic [N*CW-1:0] req_core;
   logic            rsp_valid, rsp_nofree, rsp_wr;
   logic [CW-1:0]   rsp_id, rsp_core;
   logic [N-1:0]    core_halt, core_stop, core_go, core_hub, core_busy, copy_req, copy_done;
   logic [N*PW-1:0] core_pc, core_ptra, core_ptrb;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   launch_ctrl #(.NUM_CORES(N), .PTR_W(PW), .LOCAL_LONGS(512)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_desc(req_desc),
      .req_core(req_core), .req_alloc(req_alloc), .req_hubx(req_hubx),
      .req_reg(req_reg), .req_gnt(req_gnt), .rsp_valid(rsp_valid),
      .rsp_id(rsp_id), .rsp_core(rsp_core), .rsp_nofree(rsp_nofree),
      .rsp_wr(rsp_wr), .core_halt(core_halt), .core_stop(core_stop),
      .core_go(core_go), .core_hub(core_hub), .core_pc(core_pc),
      .core_ptra(core_ptra), .core_ptrb(core_ptrb), .core_busy(core_busy),
      .copy_req(copy_req), .copy_done(copy_done)
   );

   initial begin
      clk = 1'b0;
      forever #10 clk = ~clk;
   end

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
         report();
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      chk(act === exp, tag, act, exp);
   endtask

   function automatic logic [PW-1:0] pc_of(input int c);
      return core_pc[c*PW +: PW];
   endfunction
   function automatic logic [PW-1:0] pa_of(input int c);
      return core_ptra[c*PW +: PW];
   endfunction
   function automatic logic [PW-1:0] pb_of(input int c);
      return core_ptrb[c*PW +: PW];
   endfunction

   task automatic set_req(input int r, input logic [31:0] d, input int core,
                          input bit alloc, input bit hubx, input bit rg);
      req_desc[r*DW +: DW]  = d;
      req_core[r*CW +: CW]  = CW'(core);
      req_alloc[r]          = alloc;
      req_hubx[r]           = hubx;
      req_reg[r]            = rg;
      req_valid[r]          = 1'b1;
   endtask

   // Issue from requester 0 at a negedge; return at the negedge after the grant edge.
   task automatic launch(input logic [31:0] d, input int core, input bit alloc,
                         input bit hubx, input bit rg);
      set_req(0, d, core, alloc, hubx, rg);
      #1;
      while (!req_gnt[0]) @(negedge clk);
      @(negedge clk);
      req_valid[0] = 1'b0;
   endtask

   task automatic t_reset();
      chk_eq("R1 busy", 32'(core_busy), 0);
      chk_eq("R1 go/stop", {core_go, core_stop}, 0);
      chk_eq("R1 copy_req", 32'(copy_req), 0);
      chk_eq("R1 rsp_valid", 32'(rsp_valid), 0);
      chk_eq("R1 gnt", 32'(req_gnt), 0);
      chk_eq("R1 ptrs", 32'(core_ptrb | core_ptra), 0);
   endtask

   task automatic t_named_xip_high();
      launch(32'h1234_0400, 1, 1'b0, 1'b1, 1'b1);
      chk_eq("R3 rsp_core", 32'(rsp_core), 1);
      chk_eq("R3 rsp_valid", 32'(rsp_valid), 1);
      chk_eq("R2 ptra", 32'(pa_of(1)), 32'h1234);
      chk_eq("R2 ptrb", 32'(pb_of(1)), 32'h0400);
      chk_eq("R9 go", 32'(core_go), 32'b0010);
      chk_eq("R9 hub", 32'(core_hub[1]), 1);
      chk_eq("R9 pc", 32'(pc_of(1)), 32'h0400);
      chk_eq("R9 copy_req", 32'(copy_req), 0);
      chk_eq("R7 named no wr", 32'(rsp_wr), 0);
   endtask

   task automatic t_named_xip_low();
      launch(32'h0000_01FF, 2, 1'b0, 1'b1, 1'b0);
      chk_eq("R10 go", 32'(core_go), 32'b0100);
      chk_eq("R10 hub low", 32'(core_hub[2]), 0);
      chk_eq("R10 pc", 32'(pc_of(2)), 32'h01FF);
      chk_eq("R10 copy_req", 32'(copy_req), 0);
   endtask

   task automatic t_alloc_load();
      launch(32'h0055_1000, 0, 1'b1, 1'b0, 1'b1);
      chk_eq("R5 lowest idle", 32'(rsp_core), 0);
      chk_eq("R7 wr with reg", 32'(rsp_wr), 1);
      chk_eq("R8 copy_req", 32'(copy_req), 32'b0001);
      chk_eq("R8 no go yet", 32'(core_go), 0);
      chk_eq("R2 ptrb copy src", 32'(pb_of(0)), 32'h1000);
      repeat (3) @(negedge clk);
      chk_eq("R8 copy held", 32'(copy_req), 32'b0001);
      copy_done[0] = 1'b1;
      @(negedge clk);
      copy_done[0] = 1'b0;
      chk_eq("R8 go after copy", 32'(core_go), 32'b0001);
      chk_eq("R8 hub low", 32'(core_hub[0]), 0);
      chk_eq("R8 pc zero", 32'(pc_of(0)), 0);
      chk_eq("R8 copy dropped", 32'(copy_req), 0);
   endtask

   task automatic t_alloc_imm();
      launch(32'h0000_0800, 0, 1'b1, 1'b1, 1'b0);
      chk_eq("R5 picks 3", 32'(rsp_core), 3);
      chk_eq("R7 no wr imm", 32'(rsp_wr), 0);
      chk_eq("R9 hub 3", 32'(core_hub[3]), 1);
   endtask

   task automatic t_nofree();
      launch(32'h7777_7777, 0, 1'b1, 1'b1, 1'b1);
      chk_eq("R6 nofree", 32'(rsp_nofree), 1);
      chk_eq("R6 no go/stop", {core_go, core_stop}, 0);
      chk_eq("R6 ptrb3 kept", 32'(pb_of(3)), 32'h0800);
      chk_eq("R6 ptra2 kept", 32'(pa_of(2)), 0);
   endtask

   task automatic t_restart();
      launch(32'hAAAA_0300, 1, 1'b0, 1'b1, 1'b0);
      chk_eq("R4 stop", 32'(core_stop), 32'b0010);
      chk_eq("R4 go", 32'(core_go), 32'b0010);
      chk_eq("R4 busy kept", 32'(core_busy[1]), 1);
      chk_eq("R4 new ptra", 32'(pa_of(1)), 32'hAAAA);
      @(negedge clk);
      chk_eq("R4 stop one pulse", 32'(core_stop), 0);
   endtask

   task automatic t_halt();
      core_halt[3] = 1'b1;
      @(negedge clk);
      core_halt[3] = 1'b0;
      chk_eq("R12 idle", 32'(core_busy), 32'b0111);
      launch(32'h0001_0200, 0, 1'b1, 1'b1, 1'b1);
      chk_eq("R5 refill 3", 32'(rsp_core), 3);
      chk_eq("R9 boundary hub", 32'(core_hub[3]), 1);
   endtask

   task automatic t_rr();
      // last granted requester is 0, so order is 2, 3, 0
      set_req(2, 32'h0002_0400, 2, 1'b0, 1'b1, 1'b0);
      set_req(3, 32'h0003_0400, 3, 1'b0, 1'b1, 1'b0);
      set_req(0, 32'h0004_0400, 0, 1'b0, 1'b1, 1'b0);
      #1;
      chk_eq("R11 first gnt", 32'(req_gnt), 32'b0100);
      @(negedge clk);
      req_valid[2] = 1'b0;
      chk_eq("R11 id 2", 32'(rsp_id), 2);
      #1;
      chk_eq("R11 second gnt", 32'(req_gnt), 32'b1000);
      @(negedge clk);
      req_valid[3] = 1'b0;
      chk_eq("R11 id 3", 32'(rsp_id), 3);
      #1;
      chk_eq("R11 wrap gnt", 32'(req_gnt), 32'b0001);
      @(negedge clk);
      req_valid[0] = 1'b0;
      chk_eq("R11 id 0", 32'(rsp_id), 0);
      chk_eq("R11 ptra 0", 32'(pa_of(0)), 32'h0004);
   endtask

   initial begin
      rst_n = 1'b0;
      req_valid = '0; req_alloc = '0; req_hubx = '0; req_reg = '0;
      req_desc = '0; req_core = '0; core_halt = '0; copy_done = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_named_xip_high();
      t_named_xip_low();
      t_alloc_load();
      t_alloc_imm();
      t_nofree();
      t_restart();
      t_halt();
      t_rr();
      report();
   end

endmodule